// File: doc/BRIEF.md
# E1 Overhead Auto-Response Inserter

This block lives in the transmit path of an E1 framer. It takes over the spare overhead bits of the odd-numbered frames, which do not carry the alignment word. These are the remote alarm bit A, the Sa5 bit, the Sa6 bit and, in two frames, the CRC-4 E bit. It does this when the receive side reports an incoming alarm indication signal (AIS) or a far-end block error. An 8-bit control word chooses one canned pattern per condition. When no response is active, the block stays silent, so the frame assembler uses its own default or software-supplied overhead.

A transmit timing counter supplies a frame strobe and the frame number (0 to 15) inside the CRC-4 multiframe. Conditions are sampled once, when the strobe for frame 0 arrives. The chosen response then holds for that whole multiframe. A far-end block error is remembered from the moment it is seen until the next multiframe start. Its response therefore covers the multiframe that follows the error. For each frame the block registers a set of bit values and an override flag. These stay stable until the next frame strobe.

Top module: `e1_oh_autoresp`

## Requirements
- R1: After reset, every output is 0 and no response is selected.
- R2: With control bit 7 set and AIS asserted at a multiframe start, every odd frame of that multiframe overrides with A=1, Sa5=1, Sa6=1. The E bits are not overridden.
- R3: With control bit 6 set (and bit 7 clear) and AIS asserted at a multiframe start, every odd frame overrides with A=0, Sa5=1, Sa6=1. The E bits are not overridden.
- R4: A far-end block error is a received E bit of 0 while the E-valid input is high. It selects the FEBE response for the next multiframe only. A received E bit of 1 does nothing.
- R5: FEBE select (control bits 3:2) = 01 gives A=0, Sa5=1, Sa6 nibble 0000, and E=0 in the E frames.
- R6: FEBE select = 10 gives A=0, Sa5=0, Sa6 nibble 0000, and E=0 in the E frames.
- R7: FEBE select = 11 gives A=0, Sa5=1, Sa6 nibble 0001, and E=1 in the E frames.
- R8: FEBE select = 00 disables the FEBE response. With no response active, the override flag stays 0.
- R9: If AIS and FEBE responses are both eligible, the AIS response wins. If both AIS enables are set, the bit-7 pattern wins.
- R10: A condition that appears after frame 0 of a multiframe has no effect before the next multiframe start.
- R11: The override flag is only ever 1 in odd frames. The E-override flag is only ever 1 in frames 13 and 15, and only under a FEBE response. When an override flag is 0, its bit outputs are 0.
- R12: Control bits 5, 4, 1 and 0 have no effect.
- R13: The Sa6 nibble goes out MSB first, one bit per odd frame. Frames 1, 3, 5 and 7 carry bits 3, 2, 1 and 0. Frames 9 to 15 repeat the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_i | input | 8 | Control word: bit 7 AIS pattern 1, bit 6 AIS pattern 2, bits 3:2 FEBE select |
| ais_det_i | input | 1 | AIS detected by the receive side |
| rx_e_vld_i | input | 1 | Received E bit is valid this cycle |
| rx_e_bit_i | input | 1 | Received E bit value |
| frm_tick_i | input | 1 | One-cycle strobe at the start of each frame |
| frm_idx_i | input | 4 | Frame number within the multiframe, valid with the strobe |
| ovr_vld_o | output | 1 | Use A, Sa5 and Sa6 from this block in the current frame |
| a_bit_o | output | 1 | Remote alarm bit value |
| sa5_bit_o | output | 1 | Sa5 bit value |
| sa6_bit_o | output | 1 | Sa6 bit value for this frame |
| e_vld_o | output | 1 | Use the E bit from this block in the current frame |
| e_bit_o | output | 1 | E bit value |

## Verification
The bench goes after the points that are easy to get wrong.
- Sa6 bit order: a design that sends the nibble LSB first puts the 0001 pattern in frames 1 and 9 instead of 7 and 15.
- Sampling time: AIS raised in the middle of a multiframe must not change that multiframe. A design that samples every frame would override the remaining odd frames at once.
- FEBE delay: the response must appear in the multiframe after the error and then drop away. A design without the stored error flag, or one that never clears it, fails one of these two multiframes.
- Priority and reserved bits: AIS beats FEBE, pattern 1 beats pattern 2, and the reserved control bits are set to show they change nothing.

// File: rtl/e1_oh_pkg.sv
// Package: shared types and control-word layout for the E1 overhead
// auto-response inserter.
// Assumes an 8-bit control word; bit positions are fixed by the register layout.
package e1_oh_pkg;

    localparam int CTRL_W       = 8;
    localparam int CTL_AIS_P1   = 7;   // AIS pattern 1 enable
    localparam int CTL_AIS_P2   = 6;   // AIS pattern 2 enable
    localparam int CTL_FEBE_HI  = 3;   // FEBE select, upper bit
    localparam int CTL_FEBE_LO  = 2;   // FEBE select, lower bit
    localparam int SA6_NIB_W    = 4;   // Sa6 nibble width

    // Selected response for one multiframe.
    typedef enum logic [2:0] {
        RSP_NONE    = 3'd0,
        RSP_AIS_HI  = 3'd1,   // AIS, alarm bit set
        RSP_AIS_LO  = 3'd2,   // AIS, alarm bit clear
        RSP_FEBE_S5 = 3'd3,   // FEBE select 01
        RSP_FEBE_Z  = 3'd4,   // FEBE select 10
        RSP_FEBE_E1 = 3'd5    // FEBE select 11
    } rsp_mode_e;

    // Bit values a response drives.
    typedef struct packed {
        logic                 a;
        logic                 sa5;
        logic [SA6_NIB_W-1:0] sa6_nib;
        logic                 e_en;
        logic                 e;
    } rsp_pat_t;

endpackage

// File: rtl/e1_oh_cond_track.sv
// Condition tracker: remembers far-end block errors seen during a
// multiframe and, at each multiframe start, picks the response mode for
// the coming multiframe from AIS, the stored error and the control word.
// Assumes frm_idx_i is valid whenever frm_tick_i is high.
module e1_oh_cond_track
    import e1_oh_pkg::*;
#(
    parameter int FRAME_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              ais_det_i,
    input  logic              rx_e_vld_i,
    input  logic              rx_e_bit_i,
    input  logic              frm_tick_i,
    input  logic [FRAME_W-1:0] frm_idx_i,
    output rsp_mode_e         mode_o
);

    logic      mf_start;
    logic      febe_evt;
    logic      febe_seen_q;
    logic      febe_now;
    logic      ais_p1_en;
    logic      ais_p2_en;
    logic [1:0] febe_sel;
    rsp_mode_e mode_q;
    rsp_mode_e mode_next;

    // Decode the multiframe boundary and the raw error event.
    always_comb begin
        mf_start  = frm_tick_i && (frm_idx_i == '0);
        febe_evt  = rx_e_vld_i && !rx_e_bit_i;
        febe_now  = febe_seen_q || febe_evt;
        ais_p1_en = ctrl_i[CTL_AIS_P1];
        ais_p2_en = ctrl_i[CTL_AIS_P2];
        febe_sel  = {ctrl_i[CTL_FEBE_HI], ctrl_i[CTL_FEBE_LO]};
    end

    // Hold a far-end block error until the next multiframe start consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            febe_seen_q <= 1'b0;
        end else if (mf_start) begin
            febe_seen_q <= 1'b0;
        end else if (febe_evt) begin
            febe_seen_q <= 1'b1;
        end
    end

    // Priority selection: AIS pattern 1, AIS pattern 2, then FEBE select.
    always_comb begin
        mode_next = RSP_NONE;
        if (ais_det_i && ais_p1_en) begin
            mode_next = RSP_AIS_HI;
        end else if (ais_det_i && ais_p2_en) begin
            mode_next = RSP_AIS_LO;
        end else if (febe_now) begin
            unique case (febe_sel)
                2'b01:   mode_next = RSP_FEBE_S5;
                2'b10:   mode_next = RSP_FEBE_Z;
                2'b11:   mode_next = RSP_FEBE_E1;
                default: mode_next = RSP_NONE;
            endcase
        end
    end

    // Latch the response mode only at a multiframe start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= RSP_NONE;
        end else if (mf_start) begin
            mode_q <= mode_next;
        end
    end

    assign mode_o = mode_q;

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_start |=> $stable(mode_q)); // R10
    AST_AIS_P1_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_start && ais_det_i && ctrl_i[CTL_AIS_P1]) |=> (mode_q == RSP_AIS_HI)); // R9
    AST_AIS_OVER_FEBE: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_start && ais_det_i && ctrl_i[CTL_AIS_P2]) |=>
        (mode_q == RSP_AIS_HI || mode_q == RSP_AIS_LO)); // R9
    AST_FEBE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_start && ctrl_i[CTL_FEBE_HI:CTL_FEBE_LO] == 2'b00 &&
         !(ais_det_i && (ctrl_i[CTL_AIS_P1] || ctrl_i[CTL_AIS_P2])))
        |=> (mode_q == RSP_NONE)); // R8

endmodule

// File: rtl/e1_oh_pattern.sv
// Pattern table: maps a response mode to the bit values it drives.
// Purely combinational; assumes the mode is already registered.
module e1_oh_pattern
    import e1_oh_pkg::*;
(
    input  rsp_mode_e mode_i,
    output rsp_pat_t  pat_o
);

    // Canned pattern per response mode.
    always_comb begin
        pat_o = '0;
        unique case (mode_i)
            RSP_AIS_HI: begin
                pat_o.a       = 1'b1;
                pat_o.sa5     = 1'b1;
                pat_o.sa6_nib = {SA6_NIB_W{1'b1}};
            end
            RSP_AIS_LO: begin
                pat_o.a       = 1'b0;
                pat_o.sa5     = 1'b1;
                pat_o.sa6_nib = {SA6_NIB_W{1'b1}};
            end
            RSP_FEBE_S5: begin
                pat_o.sa5     = 1'b1;
                pat_o.sa6_nib = 4'b0000;
                pat_o.e_en    = 1'b1;
                pat_o.e       = 1'b0;
            end
            RSP_FEBE_Z: begin
                pat_o.sa5     = 1'b0;
                pat_o.sa6_nib = 4'b0000;
                pat_o.e_en    = 1'b1;
                pat_o.e       = 1'b0;
            end
            RSP_FEBE_E1: begin
                pat_o.sa5     = 1'b1;
                pat_o.sa6_nib = 4'b0001;
                pat_o.e_en    = 1'b1;
                pat_o.e       = 1'b1;
            end
            default: pat_o = '0;
        endcase
    end

endmodule

// File: rtl/e1_oh_frame_sel.sv
// Frame selector: on every frame strobe, works out which overhead bits of
// the new frame are overridden and registers their values.
// Assumes odd frame numbers are the non-alignment frames and that a
// sub-multiframe holds SUBMF_FRAMES frames.
module e1_oh_frame_sel
    import e1_oh_pkg::*;
#(
    parameter int FRAME_W      = 4,
    parameter int SUBMF_FRAMES = 8,
    parameter int E_FRAME_A    = 13,
    parameter int E_FRAME_B    = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frm_tick_i,
    input  logic [FRAME_W-1:0] frm_idx_i,
    input  logic               rsp_on_i,
    input  rsp_pat_t           pat_i,
    output logic               ovr_vld_o,
    output logic               a_bit_o,
    output logic               sa5_bit_o,
    output logic               sa6_bit_o,
    output logic               e_vld_o,
    output logic               e_bit_o
);

    localparam int SUBMF_W = $clog2(SUBMF_FRAMES);
    localparam int SLOT_W  = (SUBMF_W > 1) ? SUBMF_W - 1 : 1;

    logic [FRAME_W-1:0] idx_q;
    logic               nfas;
    logic               e_slot;
    logic [SLOT_W-1:0]  slot;
    logic [1:0]         bit_sel;
    logic               ovr_n;
    logic               e_ovr_n;

    // Locate the new frame: odd frame, Sa6 slot within sub-multiframe, E slot.
    always_comb begin
        nfas    = frm_idx_i[0];
        slot    = frm_idx_i[SUBMF_W-1:1];
        bit_sel = 2'(SA6_NIB_W - 1) - 2'(slot);
        e_slot  = (frm_idx_i == FRAME_W'(E_FRAME_A)) || (frm_idx_i == FRAME_W'(E_FRAME_B));
        ovr_n   = rsp_on_i && nfas;
        e_ovr_n = ovr_n && pat_i.e_en && e_slot;
    end

    // Register the per-frame bit values at each frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            ovr_vld_o <= 1'b0;
            a_bit_o   <= 1'b0;
            sa5_bit_o <= 1'b0;
            sa6_bit_o <= 1'b0;
            e_vld_o   <= 1'b0;
            e_bit_o   <= 1'b0;
        end else if (frm_tick_i) begin
            idx_q     <= frm_idx_i;
            ovr_vld_o <= ovr_n;
            a_bit_o   <= ovr_n && pat_i.a;
            sa5_bit_o <= ovr_n && pat_i.sa5;
            sa6_bit_o <= ovr_n && pat_i.sa6_nib[bit_sel];
            e_vld_o   <= e_ovr_n;
            e_bit_o   <= e_ovr_n && pat_i.e;
        end
    end

    AST_FAS_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_q[0] |-> !ovr_vld_o); // R11
    AST_E_SLOT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        e_vld_o |-> (ovr_vld_o && (idx_q == FRAME_W'(E_FRAME_A) || idx_q == FRAME_W'(E_FRAME_B)))); // R11
    AST_QUIET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr_vld_o |-> !(a_bit_o || sa5_bit_o || sa6_bit_o || e_bit_o)); // R11
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_tick_i |=> $stable(ovr_vld_o) && $stable(sa6_bit_o)); // R13

endmodule

// File: rtl/e1_oh_autoresp.sv
// E1 overhead auto-response inserter, top level.
// Chooses a canned A/Sa5/Sa6/E response once per CRC-4 multiframe from
// AIS and far-end block error reports, then emits the per-frame bits.
// Assumes a timing counter supplies one strobe per frame with its number.
module e1_oh_autoresp
    import e1_oh_pkg::*;
#(
    parameter int FRAME_W      = 4,
    parameter int SUBMF_FRAMES = 8,
    parameter int E_FRAME_A    = 13,
    parameter int E_FRAME_B    = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CTRL_W-1:0]  ctrl_i,
    input  logic               ais_det_i,
    input  logic               rx_e_vld_i,
    input  logic               rx_e_bit_i,
    input  logic               frm_tick_i,
    input  logic [FRAME_W-1:0] frm_idx_i,
    output logic               ovr_vld_o,
    output logic               a_bit_o,
    output logic               sa5_bit_o,
    output logic               sa6_bit_o,
    output logic               e_vld_o,
    output logic               e_bit_o
);

    rsp_mode_e mode;
    rsp_pat_t  pat;
    logic      rsp_on;

    e1_oh_cond_track #(
        .FRAME_W (FRAME_W)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_i     (ctrl_i),
        .ais_det_i  (ais_det_i),
        .rx_e_vld_i (rx_e_vld_i),
        .rx_e_bit_i (rx_e_bit_i),
        .frm_tick_i (frm_tick_i),
        .frm_idx_i  (frm_idx_i),
        .mode_o     (mode)
    );

    e1_oh_pattern u_pat (
        .mode_i (mode),
        .pat_o  (pat)
    );

    // A response is active whenever a mode other than none is held.
    assign rsp_on = (mode != RSP_NONE);

    e1_oh_frame_sel #(
        .FRAME_W      (FRAME_W),
        .SUBMF_FRAMES (SUBMF_FRAMES),
        .E_FRAME_A    (E_FRAME_A),
        .E_FRAME_B    (E_FRAME_B)
    ) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_tick_i (frm_tick_i),
        .frm_idx_i  (frm_idx_i),
        .rsp_on_i   (rsp_on),
        .pat_i      (pat),
        .ovr_vld_o  (ovr_vld_o),
        .a_bit_o    (a_bit_o),
        .sa5_bit_o  (sa5_bit_o),
        .sa6_bit_o  (sa6_bit_o),
        .e_vld_o    (e_vld_o),
        .e_bit_o    (e_bit_o)
    );

endmodule

// File: tb/e1_oh_autoresp_tb.sv
// Directed bench: one task per scenario, each checking its own multiframes.
module e1_oh_autoresp_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ctrl = 8'h00;
    logic       ais = 1'b0;
    logic       e_vld = 1'b0;
    logic       e_bit = 1'b1;
    logic       tick = 1'b0;
    logic [3:0] idx = 4'd0;
    logic       ovr, a_o, sa5_o, sa6_o, ev_o, e_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Expected-mode codes used by the bench model.
    localparam int M_NONE = 0, M_AIS1 = 1, M_AIS2 = 2, M_F01 = 3, M_F10 = 4, M_F11 = 5;

    always #4 clk = ~clk;   // 125 MHz

    e1_oh_autoresp u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_i     (ctrl),
        .ais_det_i  (ais),
        .rx_e_vld_i (e_vld),
        .rx_e_bit_i (e_bit),
        .frm_tick_i (tick),
        .frm_idx_i  (idx),
        .ovr_vld_o  (ovr),
        .a_bit_o    (a_o),
        .sa5_bit_o  (sa5_o),
        .sa6_bit_o  (sa6_o),
        .e_vld_o    (ev_o),
        .e_bit_o    (e_o)
    );

    // Expected {ovr, a, sa5, sa6, e_vld, e} for a mode and frame number.
    function automatic logic [5:0] model(int m, int k);
        logic odd, es;
        logic a, s5, ee, een;
        logic [3:0] nib;
        odd = (k % 2) == 1;
        es  = (k == 13) || (k == 15);
        a = 0; s5 = 0; nib = 4'h0; een = 0; ee = 0;
        case (m)
            M_AIS1: begin a = 1; s5 = 1; nib = 4'hF; end
            M_AIS2: begin a = 0; s5 = 1; nib = 4'hF; end
            M_F01:  begin s5 = 1; nib = 4'h0; een = 1; ee = 0; end
            M_F10:  begin s5 = 0; nib = 4'h0; een = 1; ee = 0; end
            M_F11:  begin s5 = 1; nib = 4'h1; een = 1; ee = 1; end
            default: ;
        endcase
        if (m == M_NONE || !odd) return 6'b0;
        return {1'b1, a, s5, nib[3 - ((k % 8) / 2)], een && es, een && es && ee};
    endfunction

    task automatic check(string req, logic [5:0] act, logic [5:0] exp, int k);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s frame %0d: got %b expected %b", req, k, act, exp);
        end
    endtask

    // Run one multiframe, optionally raising AIS or pulsing an E bit at a frame.
    task automatic run_mf(int exp_m, string req, int ais_at, int err_at, logic err_val);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            tick = 1'b1;
            idx  = 4'(k);
            if (k == ais_at) ais = 1'b1;
            if (k == err_at) begin e_vld = 1'b1; e_bit = err_val; end
            @(negedge clk);
            tick  = 1'b0;
            e_vld = 1'b0;
            e_bit = 1'b1;
            check(req, {ovr, a_o, sa5_o, sa6_o, ev_o, e_o}, model(exp_m, k), k);
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", {ovr, a_o, sa5_o, sa6_o, ev_o, e_o}, 6'b0, 0);
    endtask

    task automatic t_idle();
        ctrl = 8'h00; ais = 1'b1;
        run_mf(M_NONE, "R8 all disabled", -1, 5, 1'b0);
        ais = 1'b0;
    endtask

    task automatic t_ais();
        ctrl = 8'h80; ais = 1'b1;
        run_mf(M_AIS1, "R2 R11 R13 AIS pattern 1", -1, -1, 1'b1);
        ctrl = 8'h40;
        run_mf(M_AIS2, "R3 AIS pattern 2", -1, -1, 1'b1);
        ctrl = 8'hC0;
        run_mf(M_AIS1, "R9 both AIS enables", -1, -1, 1'b1);
        ais = 1'b0;
        run_mf(M_NONE, "R8 AIS cleared", -1, -1, 1'b1);
    endtask

    task automatic t_febe(logic [7:0] c, int m, string req);
        ctrl = c;
        run_mf(M_NONE, req, -1, 10, 1'b0);
        run_mf(m, req, -1, -1, 1'b1);
        run_mf(M_NONE, "R4 FEBE expires", -1, -1, 1'b1);
    endtask

    task automatic t_febe_misc();
        ctrl = 8'h00;
        run_mf(M_NONE, "R8 select 00", -1, 10, 1'b0);
        run_mf(M_NONE, "R8 select 00 next", -1, -1, 1'b1);
        ctrl = 8'h0C;
        run_mf(M_NONE, "R4 E bit one", -1, 10, 1'b1);
        run_mf(M_NONE, "R4 E bit one next", -1, -1, 1'b1);
    endtask

    task automatic t_prio();
        ctrl = 8'h44; ais = 1'b1;
        run_mf(M_AIS2, "R9 AIS over FEBE", -1, 10, 1'b0);
        run_mf(M_AIS2, "R9 AIS over FEBE held", -1, -1, 1'b1);
        ais = 1'b0;
        run_mf(M_NONE, "R9 after AIS", -1, -1, 1'b1);
    endtask

    task automatic t_midmf();
        ctrl = 8'h80; ais = 1'b0;
        run_mf(M_NONE, "R10 AIS mid multiframe", 5, -1, 1'b1);
        run_mf(M_AIS1, "R10 AIS next multiframe", -1, -1, 1'b1);
        ais = 1'b0;
        run_mf(M_NONE, "R10 AIS gone", -1, -1, 1'b1);
    endtask

    task automatic t_reserved();
        ctrl = 8'h33; ais = 1'b1;
        run_mf(M_NONE, "R12 reserved bits only", -1, 10, 1'b0);
        ctrl = 8'hB3;
        run_mf(M_AIS1, "R12 reserved with AIS 1", -1, -1, 1'b1);
        ais = 1'b0; ctrl = 8'h3B;
        run_mf(M_NONE, "R12 reserved with select 10", -1, 10, 1'b0);
        run_mf(M_F10, "R12 select 10 response", -1, -1, 1'b1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_ais();
        t_febe(8'h04, M_F01, "R4 R5 select 01");
        t_febe(8'h08, M_F10, "R6 select 10");
        t_febe(8'h0C, M_F11, "R7 R13 select 11");
        t_febe_misc();
        t_prio();
        t_midmf();
        t_reserved();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule